// File: doc/BRIEF.md
# Segment Selector Load Protection Checker

This block decides whether a 16-bit segment selector may be placed in one of the six segment registers. Alongside the selector, the requester supplies the current privilege level and the byte limits of the global and local descriptor tables. It also supplies the 64-bit descriptor that the selector names, which has already been fetched elsewhere. For a code-segment load that goes through a call gate, it adds a gate flag and the gate's privilege level. The block returns a verdict, a fault class and the privilege level the processor runs at once the load is done.

One check is carried per request. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The verdict is held in a response register until the consumer takes it with `rsp_ready`. No new request is taken while a response is pending. The checks follow a fixed priority: null selector, table bound, segment class, type per destination register, privilege, and presence. Only the first check that fails is reported.

Top module: `seg_load_guard`

## Requirements
- R1: `req_ready` is high exactly when no response is pending. A request accepted on an edge gives `rsp_valid` high from that edge on. The response stays high with stable fault and privilege outputs until an edge where `rsp_ready` is high, and `rsp_valid` is low after that edge.
- R2: The selector is decoded as index in bits 15..3, table select in bit 2 (0 global, 1 local) and requested level in bits 1..0. The destination codes are 0 code (CS), 1 stack (SS), and 2..5 the four data registers (DS, ES, FS, GS). Codes 6 and 7 always give a general protection fault.
- R3: A null selector is index 0 with table select 0. It passes for destinations 2..5 and gives a general protection fault for destinations 0 and 1.
- R4: A non-null selector whose index*8+7 exceeds the limit of the table chosen by bit 2 gives a general protection fault.
- R5: A descriptor with bit 44 (code/data class) clear gives a general protection fault.
- R6: Descriptor type bits 43..41 are: bit 43 executable; bit 42 conforming for code, expand-down for data; bit 41 readable for code, writable for data. For destinations 2..5, an executable segment that is not readable gives a general protection fault. Data segments and readable code segments pass this check.
- R7: Destination 1 accepts only a writable data segment; anything else gives a general protection fault.
- R8: For destinations 2..5 the load passes only if max(RPL,CPL) <= DPL, where DPL is descriptor bits 46..45. Otherwise it gives a general protection fault.
- R9: Destination 1 passes only if DPL equals CPL; otherwise it gives a general protection fault.
- R10: A direct load of destination 0 needs an executable segment. Non-conforming code needs DPL equal to CPL, and conforming code needs DPL <= CPL. Any other case gives a general protection fault. A successful direct load returns the current CPL unchanged, and so does every successful load of destinations 1..5.
- R11: A load of destination 0 through a call gate passes only if target DPL <= max(RPL,CPL) <= gate DPL. On success the returned CPL is the target DPL.
- R12: A descriptor that passes every earlier check but has bit 47 (present) clear gives a not-present fault. For destination 1 it gives a stack fault instead. A privilege or type failure takes priority over absence.
- R13: Fault codes are 0 none, 1 general protection, 2 stack fault and 3 not present. `rsp_ok` is high exactly when the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_dest | input | 3 | Destination register code |
| req_sel | input | 16 | Selector to load |
| req_cpl | input | 2 | Current privilege level |
| req_gdt_limit | input | 16 | Global table byte limit |
| req_ldt_limit | input | 16 | Local table byte limit |
| req_desc | input | 64 | Descriptor named by the selector (target code descriptor for a gate) |
| req_via_gate | input | 1 | Code load goes through a call gate |
| req_gate_dpl | input | 2 | Privilege level of the call gate |
| rsp_valid | output | 1 | Verdict available |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_ok | output | 1 | Load permitted |
| rsp_fault | output | 2 | Fault class |
| rsp_cpl | output | 2 | Privilege level after the load |

## Verification
Some properties are checked on every cycle. The response is held while it waits, and an accepted request always yields a response. A null data-register load never faults, and an out-of-bound index always gives a general protection fault. A stack load with a mismatched level never passes. The returned level follows the current level unless a gate is used, and follows the target level when a gate load succeeds. The bench scenarios alone show the full priority order: type against privilege against presence, the conforming and gate boundaries at equal and unequal levels, the choice between stack and not-present fault for absent segments, and rejection of the two unused destination codes.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  localparam int SEL_W    = 16;
  localparam int DESC_W   = 64;
  localparam int PL_W     = 2;
  localparam int DEST_W   = 3;
  localparam int NUM_DEST = 6;
  localparam int NUM_LANE = 1 << DEST_W;

  // selector layout
  localparam int TI_BIT      = 2;
  localparam int ENTRY_SHIFT = TI_BIT + 1;
  localparam int IDX_W       = SEL_W - ENTRY_SHIFT;

  // descriptor attribute positions
  localparam int D_PRESENT = 47;
  localparam int D_DPL_LSB = 45;
  localparam int D_CLASS   = 44;
  localparam int D_EXEC    = 43;
  localparam int D_CONF    = 42;
  localparam int D_RW      = 41;

  // destination codes
  localparam logic [DEST_W-1:0] DST_CODE  = 3'd0;
  localparam logic [DEST_W-1:0] DST_STACK = 3'd1;
  localparam logic [DEST_W-1:0] DST_DAT0  = 3'd2;
  localparam logic [DEST_W-1:0] DST_DAT3  = 3'd5;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_GP     = 2'd1,
    FLT_STACK  = 2'd2,
    FLT_ABSENT = 2'd3
  } fault_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             ti;
    logic [PL_W-1:0]  rpl;
  } sel_t;

  typedef struct packed {
    logic            present;
    logic [PL_W-1:0] dpl;
    logic            cls;
    logic            exec;
    logic            conf;
    logic            rw;
  } attr_t;

  function automatic logic [PL_W-1:0] pl_max(input logic [PL_W-1:0] a,
                                              input logic [PL_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seg_guard_fields.sv
module seg_guard_fields
  import seg_guard_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [DESC_W-1:0]  desc,
  input  logic [LIMIT_W-1:0] gdt_limit,
  input  logic [LIMIT_W-1:0] ldt_limit,
  output sel_t               fields,
  output attr_t              attr,
  output logic               is_null,
  output logic               in_range
);

  localparam int CMP_W = ((LIMIT_W > SEL_W) ? LIMIT_W : SEL_W) + 1;

  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] tbl_limit;
  logic             unused_desc_bits;

  always_comb begin
    fields    = sel_t'(sel);
    last_byte = '0;
    last_byte[SEL_W-1:0] = {fields.idx, {ENTRY_SHIFT{1'b1}}};
    tbl_limit = '0;
    tbl_limit[LIMIT_W-1:0] = fields.ti ? ldt_limit : gdt_limit;
    in_range  = (last_byte <= tbl_limit);
    is_null   = (fields.idx == '0) && !fields.ti;
  end

  always_comb begin
    attr.present = desc[D_PRESENT];
    attr.dpl     = desc[D_DPL_LSB +: PL_W];
    attr.cls     = desc[D_CLASS];
    attr.exec    = desc[D_EXEC];
    attr.conf    = desc[D_CONF];
    attr.rw      = desc[D_RW];
  end

  assign unused_desc_bits = ^{desc[DESC_W-1:D_PRESENT+1], desc[D_RW-1:0]};

endmodule

// File: rtl/seg_guard_rules.sv
module seg_guard_rules
  import seg_guard_pkg::*;
(
  input  logic [DEST_W-1:0] dest,
  input  logic [PL_W-1:0]   cpl,
  input  sel_t              fields,
  input  attr_t             attr,
  input  logic              is_null,
  input  logic              in_range,
  input  logic              via_gate,
  input  logic [PL_W-1:0]   gate_dpl,
  output fault_e            fault,
  output logic [PL_W-1:0]   cpl_next
);

  logic [PL_W-1:0]     eff_pl;
  logic [NUM_LANE-1:0] lane_null_ok;
  logic [NUM_LANE-1:0] lane_type_ok;
  logic [NUM_LANE-1:0] lane_priv_ok;

  assign eff_pl = pl_max(fields.rpl, cpl);

  // one lane per destination code; unused codes reject everything
  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    if (g == int'(DST_CODE)) begin : g_code
      assign lane_null_ok[g] = 1'b0;
      assign lane_type_ok[g] = attr.exec;
      assign lane_priv_ok[g] = via_gate ? ((attr.dpl <= eff_pl) && (eff_pl <= gate_dpl))
                             : attr.conf ? (attr.dpl <= cpl)
                             : (attr.dpl == cpl);
    end else if (g == int'(DST_STACK)) begin : g_stack
      assign lane_null_ok[g] = 1'b0;
      assign lane_type_ok[g] = !attr.exec && attr.rw;
      assign lane_priv_ok[g] = (attr.dpl == cpl);
    end else if (g < NUM_DEST) begin : g_data
      assign lane_null_ok[g] = 1'b1;
      assign lane_type_ok[g] = !attr.exec || attr.rw;
      assign lane_priv_ok[g] = (eff_pl <= attr.dpl);
    end else begin : g_none
      assign lane_null_ok[g] = 1'b0;
      assign lane_type_ok[g] = 1'b0;
      assign lane_priv_ok[g] = 1'b0;
    end
  end

  always_comb begin
    if (is_null) begin
      fault = lane_null_ok[dest] ? FLT_NONE : FLT_GP;
    end else if (!in_range || !attr.cls || !lane_type_ok[dest] || !lane_priv_ok[dest]) begin
      fault = FLT_GP;
    end else if (!attr.present) begin
      fault = (dest == DST_STACK) ? FLT_STACK : FLT_ABSENT;
    end else begin
      fault = FLT_NONE;
    end
  end

  always_comb begin
    cpl_next = cpl;
    if ((dest == DST_CODE) && via_gate) begin
      cpl_next = attr.dpl;
    end
  end

endmodule

// File: rtl/seg_guard_resp.sv
module seg_guard_resp
  import seg_guard_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  output logic            accept,
  input  fault_e          fault_in,
  input  logic [PL_W-1:0] cpl_in,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output fault_e          fault_q,
  output logic [PL_W-1:0] cpl_q
);

  logic pending_q;
  logic pending_d;
  logic load_en;

  assign req_ready = !pending_q;
  assign accept    = req_valid && !pending_q;
  assign load_en   = accept;
  assign rsp_valid = pending_q;

  always_comb begin
    pending_d = pending_q;
    if (accept) begin
      pending_d = 1'b1;
    end else if (rsp_ready) begin
      pending_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else begin
      pending_q <= pending_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FLT_NONE;
      cpl_q   <= '0;
    end else if (load_en) begin
      fault_q <= fault_in;
      cpl_q   <= cpl_in;
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !rsp_ready) |=> (pending_q && $stable(fault_q) && $stable(cpl_q)));

  p_accept_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

endmodule

// File: rtl/seg_load_guard.sv
module seg_load_guard
  import seg_guard_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_dest,
  input  logic [15:0]        req_sel,
  input  logic [1:0]         req_cpl,
  input  logic [LIMIT_W-1:0] req_gdt_limit,
  input  logic [LIMIT_W-1:0] req_ldt_limit,
  input  logic [63:0]        req_desc,
  input  logic               req_via_gate,
  input  logic [1:0]         req_gate_dpl,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_ok,
  output logic [1:0]         rsp_fault,
  output logic [1:0]         rsp_cpl
);

  logic            rst_meta_q;
  logic            rst_sync_n;
  sel_t            fields;
  attr_t           attr;
  logic            is_null;
  logic            in_range;
  fault_e          fault_c;
  fault_e          fault_q;
  logic [PL_W-1:0] cpl_c;
  logic [PL_W-1:0] cpl_q;
  logic            accept;

  // reset asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seg_guard_fields #(.LIMIT_W(LIMIT_W)) i_fields (
    .sel       (req_sel),
    .desc      (req_desc),
    .gdt_limit (req_gdt_limit),
    .ldt_limit (req_ldt_limit),
    .fields    (fields),
    .attr      (attr),
    .is_null   (is_null),
    .in_range  (in_range)
  );

  seg_guard_rules i_rules (
    .dest     (req_dest),
    .cpl      (req_cpl),
    .fields   (fields),
    .attr     (attr),
    .is_null  (is_null),
    .in_range (in_range),
    .via_gate (req_via_gate),
    .gate_dpl (req_gate_dpl),
    .fault    (fault_c),
    .cpl_next (cpl_c)
  );

  seg_guard_resp i_resp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .fault_in  (fault_c),
    .cpl_in    (cpl_c),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .fault_q   (fault_q),
    .cpl_q     (cpl_q)
  );

  assign rsp_fault = fault_q;
  assign rsp_ok    = (fault_q == FLT_NONE);
  assign rsp_cpl   = cpl_q;

  p_null_data_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && (req_dest >= DST_DAT0) && (req_dest <= DST_DAT3) && (req_sel[15:2] == '0))
      |=> rsp_ok);

  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && (req_sel[15:2] != '0) &&
     ({1'b0, req_sel[15:3], 3'b111} > {1'b0, (req_sel[2] ? req_ldt_limit : req_gdt_limit)}))
      |=> (rsp_fault == 2'd1));

  p_stack_level_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && (req_dest == DST_STACK) && (req_desc[46:45] != req_cpl)) |=> !rsp_ok);

  p_keep_cpl_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && !((req_dest == DST_CODE) && req_via_gate)) |=> (rsp_cpl == $past(req_cpl)));

  p_gate_cpl_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && (req_dest == DST_CODE) && req_via_gate)
      |=> (!rsp_ok || (rsp_cpl == $past(req_desc[46:45]))));

endmodule

// File: tb/test_seg_load_guard.sv
`timescale 1ns/1ps
module test_seg_load_guard;

  localparam logic [1:0] F_OK = 2'd0, F_GP = 2'd1, F_SF = 2'd2, F_NP = 2'd3;
  localparam logic [2:0] T_RO = 3'd0, T_RW = 3'd1, T_XO = 3'd4, T_XR = 3'd5,
                         T_CXO = 3'd6, T_CXR = 3'd7;
  localparam logic [2:0] D_CS = 3'd0, D_SS = 3'd1, D_DS = 3'd2, D_ES = 3'd3,
                         D_FS = 3'd4, D_GS = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [2:0]  req_dest;
  logic [15:0] req_sel;
  logic [1:0]  req_cpl;
  logic [15:0] req_gdt_limit, req_ldt_limit;
  logic [63:0] req_desc;
  logic        req_via_gate;
  logic [1:0]  req_gate_dpl;
  logic        rsp_valid, rsp_ready, rsp_ok;
  logic [1:0]  rsp_fault, rsp_cpl;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_load_guard i_seg_load_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_sel(req_sel), .req_cpl(req_cpl),
    .req_gdt_limit(req_gdt_limit), .req_ldt_limit(req_ldt_limit),
    .req_desc(req_desc), .req_via_gate(req_via_gate), .req_gate_dpl(req_gate_dpl),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .rsp_fault(rsp_fault), .rsp_cpl(rsp_cpl)
  );

  function automatic logic [63:0] mk_desc(input logic p, input logic [1:0] dpl,
                                          input logic cls, input logic [2:0] typ);
    return {16'h00CF, p, dpl, cls, typ, 1'b0, 40'h00_0000_FFFF};
  endfunction

  function automatic logic [15:0] mk_sel(input int idx, input logic ti, input logic [1:0] rpl);
    logic [12:0] i13;
    i13 = idx[12:0];
    return {i13, ti, rpl};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] dest, input logic [15:0] sel, input logic [1:0] cpl,
                       input logic [63:0] desc, input logic gate, input logic [1:0] gdpl,
                       input logic [15:0] ldt_lim);
    req_dest      = dest;
    req_sel       = sel;
    req_cpl       = cpl;
    req_desc      = desc;
    req_via_gate  = gate;
    req_gate_dpl  = gdpl;
    req_gdt_limit = 16'h00FF;
    req_ldt_limit = ldt_lim;
  endtask

  // one request, one response taken at once
  task automatic run_check(input string tag, input logic [2:0] dest, input logic [15:0] sel,
                           input logic [1:0] cpl, input logic [63:0] desc, input logic gate,
                           input logic [1:0] gdpl, input logic [15:0] ldt_lim,
                           input logic [1:0] exp_fault, input logic [1:0] exp_cpl);
    @(negedge clk);
    drive(dest, sel, cpl, desc, gate, gdpl, ldt_lim);
    req_valid = 1'b1;
    chk({tag, " R1 ready"}, int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R1 valid"}, int'(rsp_valid), 1);
    chk({tag, " R13 fault"}, int'(rsp_fault), int'(exp_fault));
    chk({tag, " R13 ok"}, int'(rsp_ok), int'(exp_fault == F_OK));
    if (exp_fault == F_OK) chk({tag, " cpl"}, int'(rsp_cpl), int'(exp_cpl));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({tag, " R1 released"}, int'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset valid", int'(rsp_valid), 0);
  endtask

  task automatic t_null_R3();
    run_check("R3 null DS", D_DS, 16'h0003, 2'd3, 64'h0, 1'b0, 2'd0, 16'h003F, F_OK, 2'd3);
    run_check("R3 null GS", D_GS, 16'h0000, 2'd0, 64'h0, 1'b0, 2'd0, 16'h003F, F_OK, 2'd0);
    run_check("R3 null CS", D_CS, 16'h0000, 2'd0, mk_desc(1, 0, 1, T_XR), 1'b0, 2'd0, 16'h003F, F_GP, 2'd0);
    run_check("R3 null SS", D_SS, 16'h0000, 2'd0, mk_desc(1, 0, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd0);
    // local index 0 is not null: goes through the descriptor checks (R2)
    run_check("R2 local idx0", D_DS, mk_sel(0, 1, 0), 2'd0, mk_desc(0, 0, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_NP, 2'd0);
  endtask

  task automatic t_bound_R4();
    run_check("R4 gdt last", D_DS, mk_sel(31, 0, 0), 2'd0, mk_desc(1, 3, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_OK, 2'd0);
    run_check("R4 gdt over", D_DS, mk_sel(32, 0, 0), 2'd0, mk_desc(1, 3, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd0);
    run_check("R4 ldt over", D_ES, mk_sel(8, 1, 0), 2'd0, mk_desc(1, 3, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd0);
    run_check("R4 ldt last", D_ES, mk_sel(7, 1, 0), 2'd0, mk_desc(1, 3, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_OK, 2'd0);
  endtask

  task automatic t_types_R5_R6_R7();
    run_check("R5 system", D_DS, mk_sel(2, 0, 0), 2'd0, mk_desc(1, 3, 0, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd0);
    run_check("R6 exec only", D_FS, mk_sel(2, 0, 0), 2'd0, mk_desc(1, 3, 1, T_XO), 1'b0, 2'd0, 16'h003F, F_GP, 2'd0);
    run_check("R6 exec read", D_FS, mk_sel(2, 0, 0), 2'd0, mk_desc(1, 3, 1, T_XR), 1'b0, 2'd0, 16'h003F, F_OK, 2'd0);
    run_check("R6 read only", D_DS, mk_sel(2, 0, 0), 2'd1, mk_desc(1, 3, 1, T_RO), 1'b0, 2'd0, 16'h003F, F_OK, 2'd1);
    run_check("R7 SS read only", D_SS, mk_sel(2, 0, 1), 2'd1, mk_desc(1, 1, 1, T_RO), 1'b0, 2'd0, 16'h003F, F_GP, 2'd1);
    run_check("R7 SS code", D_SS, mk_sel(2, 0, 1), 2'd1, mk_desc(1, 1, 1, T_XR), 1'b0, 2'd0, 16'h003F, F_GP, 2'd1);
    run_check("R7 SS writable", D_SS, mk_sel(2, 0, 1), 2'd1, mk_desc(1, 1, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_OK, 2'd1);
  endtask

  task automatic t_priv_R8_R9();
    run_check("R8 rpl weaker", D_DS, mk_sel(3, 0, 3), 2'd1, mk_desc(1, 2, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd1);
    run_check("R8 equal", D_DS, mk_sel(3, 0, 0), 2'd1, mk_desc(1, 1, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_OK, 2'd1);
    run_check("R8 cpl weaker", D_GS, mk_sel(3, 0, 0), 2'd2, mk_desc(1, 1, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd2);
    run_check("R9 SS dpl low", D_SS, mk_sel(3, 0, 3), 2'd3, mk_desc(1, 2, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd3);
    run_check("R9 SS dpl high", D_SS, mk_sel(3, 0, 0), 2'd0, mk_desc(1, 1, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd0);
  endtask

  task automatic t_code_R10();
    run_check("R10 same level", D_CS, mk_sel(4, 0, 3), 2'd3, mk_desc(1, 3, 1, T_XO), 1'b0, 2'd0, 16'h003F, F_OK, 2'd3);
    run_check("R10 higher dpl", D_CS, mk_sel(4, 0, 3), 2'd3, mk_desc(1, 0, 1, T_XO), 1'b0, 2'd0, 16'h003F, F_GP, 2'd3);
    run_check("R10 conforming in", D_CS, mk_sel(4, 0, 2), 2'd2, mk_desc(1, 1, 1, T_CXR), 1'b0, 2'd0, 16'h003F, F_OK, 2'd2);
    run_check("R10 conforming out", D_CS, mk_sel(4, 0, 2), 2'd2, mk_desc(1, 3, 1, T_CXO), 1'b0, 2'd0, 16'h003F, F_GP, 2'd2);
    run_check("R10 data as code", D_CS, mk_sel(4, 0, 2), 2'd2, mk_desc(1, 2, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd2);
  endtask

  task automatic t_gate_R11();
    run_check("R11 gate raise", D_CS, mk_sel(5, 0, 3), 2'd3, mk_desc(1, 0, 1, T_XO), 1'b1, 2'd3, 16'h003F, F_OK, 2'd0);
    run_check("R11 gate too high", D_CS, mk_sel(5, 0, 3), 2'd3, mk_desc(1, 0, 1, T_XO), 1'b1, 2'd2, 16'h003F, F_GP, 2'd0);
    run_check("R11 target low", D_CS, mk_sel(5, 0, 0), 2'd2, mk_desc(1, 3, 1, T_XO), 1'b1, 2'd3, 16'h003F, F_GP, 2'd0);
    run_check("R11 rpl lifts", D_CS, mk_sel(5, 0, 2), 2'd1, mk_desc(1, 1, 1, T_XR), 1'b1, 2'd2, 16'h003F, F_OK, 2'd1);
  endtask

  task automatic t_absent_R12();
    run_check("R12 data absent", D_DS, mk_sel(6, 0, 0), 2'd0, mk_desc(0, 0, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_NP, 2'd0);
    run_check("R12 stack absent", D_SS, mk_sel(6, 0, 0), 2'd0, mk_desc(0, 0, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_SF, 2'd0);
    run_check("R12 code absent", D_CS, mk_sel(6, 0, 0), 2'd0, mk_desc(0, 0, 1, T_XR), 1'b0, 2'd0, 16'h003F, F_NP, 2'd0);
    run_check("R12 priv first", D_DS, mk_sel(6, 0, 3), 2'd3, mk_desc(0, 0, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd3);
  endtask

  task automatic t_bad_dest_R2();
    run_check("R2 code 6", 3'd6, mk_sel(2, 0, 0), 2'd0, mk_desc(1, 3, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd0);
    run_check("R2 code 7 null", 3'd7, 16'h0000, 2'd0, mk_desc(1, 3, 1, T_RW), 1'b0, 2'd0, 16'h003F, F_GP, 2'd0);
  endtask

  // response waits; a second request is refused meanwhile
  task automatic t_hold_R1();
    @(negedge clk);
    drive(D_SS, mk_sel(6, 0, 0), 2'd0, mk_desc(0, 0, 1, T_RW), 1'b0, 2'd0, 16'h003F);
    req_valid = 1'b1;
    @(negedge clk);
    drive(D_DS, 16'h0000, 2'd1, 64'h0, 1'b0, 2'd0, 16'h003F);
    for (int k = 0; k < 3; k++) begin
      chk("R1 hold ready", int'(req_ready), 0);
      chk("R1 hold valid", int'(rsp_valid), 1);
      chk("R1 hold fault", int'(rsp_fault), int'(F_SF));
      @(negedge clk);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R1 hold drained", int'(rsp_valid), 0);
    @(negedge clk);
    chk("R1 refused request gone", int'(rsp_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    rsp_ready = 1'b0;
    drive(D_DS, 16'h0, 2'd0, 64'h0, 1'b0, 2'd0, 16'h003F);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_null_R3();
    t_bound_R4();
    t_types_R5_R6_R7();
    t_priv_R8_R9();
    t_code_R10();
    t_gate_R11();
    t_absent_R12();
    t_bad_dest_R2();
    t_hold_R1();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule